// File: doc/BRIEF.md
# Mode-Banked Register File

This block holds the general registers of a 32-bit load-store core. Software sees sixteen register indices, but several of those indices are backed by different storage depending on the processor mode supplied on `mode_i`. The exception modes each own private stack and link registers. The fast-interrupt mode also owns private copies of r8 to r12. Each exception mode also has a saved-status word. Switching modes therefore swaps the visible copies without moving any data, and the copies that are hidden keep their contents.

There are two operand read ports, A and B. Both are combinational: data follows the index and mode in the same cycle. There is one result write port, which commits on the rising clock edge. A separate port reads and writes the saved-status word of the current mode. All ports are plain per-cycle signals. There is no handshake, so a write is taken on every edge where its enable is high, and a read never stalls. The backing store has 31 general locations and 5 saved-status words. The current status word is kept outside this block.

Top module: `banked_regfile`

## Requirements
- R1: After an active-low reset, every general location and every saved-status word reads as zero.
- R2: Indices r0 to r7 and r15 select the same storage in every mode.
- R3: In fast-interrupt mode, indices r8 to r12 select a private copy. Every other mode, including unrecognised encodings, uses the user copy of r8 to r12.
- R4: Indices r13 and r14 select a private pair in each of fast-interrupt, interrupt, supervisor, abort and undefined mode. A write to r13 or r14 in one of those modes leaves the user r13/r14 unchanged.
- R5: System mode reads and writes the user copies of r8 to r14.
- R6: Mode encodings on the 5-bit `mode_i` are: 0x10 user, 0x11 fast interrupt, 0x12 interrupt, 0x13 supervisor, 0x17 abort, 0x1B undefined, 0x1F system. Any other value behaves as user mode.
- R7: Each of the five exception modes has its own saved-status word. A read returns the last value written to it while in that mode.
- R8: In user, system or unrecognised modes, `sav_rd_data` is zero and a saved-status write changes no stored word.
- R9: Both read ports are combinational and independent. A write commits at the rising edge. A read of the index being written in that same cycle returns the old value.
- R10: Contents of every bank are kept across any sequence of mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 5 | Current processor mode encoding |
| rd_a_idx | input | 4 | Architectural index for operand port A |
| rd_a_data | output | 32 | Operand A read data |
| rd_b_idx | input | 4 | Architectural index for operand port B |
| rd_b_data | output | 32 | Operand B read data |
| wr_en | input | 1 | Result write enable |
| wr_idx | input | 4 | Architectural index for the result write |
| wr_data | input | 32 | Result write data |
| sav_rd_data | output | 32 | Saved-status word of the current mode |
| sav_wr_en | input | 1 | Saved-status write enable |
| sav_wr_data | input | 32 | Saved-status write data |

## Verification
The bench writes a distinct value into r13 or r14 in each mode. It then returns to every mode and reads those values back. A map that shared a pair between two modes, or that wrote through to the user copy, would return another mode's value or corrupt the user stack pointer. It checks that r8 and r15 differ between fast-interrupt mode and the other modes only where they should, and it checks system mode and an unrecognised encoding against the user copies. It checks that a same-cycle read of the write target returns the old value, which a bypass would break. Saved-status writes in user and system mode must leave all five stored words unchanged and must read as zero.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int ARCH_N   = 16;
  localparam int IDX_W    = $clog2(ARCH_N);
  localparam int FIQ_LO   = 8;
  localparam int FIQ_HI   = 12;
  localparam int FIQ_CNT  = FIQ_HI - FIQ_LO + 1;
  localparam int SP_IDX   = 13;
  localparam int LR_IDX   = 14;
  localparam int BANK_N   = 6;
  localparam int SAV_N    = BANK_N - 1;
  localparam int PHYS_N   = ARCH_N + FIQ_CNT + 2 * SAV_N;
  localparam int PHYS_W   = $clog2(PHYS_N);

  localparam logic [4:0] MD_USR = 5'h10;
  localparam logic [4:0] MD_FIQ = 5'h11;
  localparam logic [4:0] MD_IRQ = 5'h12;
  localparam logic [4:0] MD_SVC = 5'h13;
  localparam logic [4:0] MD_ABT = 5'h17;
  localparam logic [4:0] MD_UND = 5'h1B;
  localparam logic [4:0] MD_SYS = 5'h1F;

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5
  } bank_e;
endpackage

// File: rtl/brf_mode_decode.sv
module brf_mode_decode
  import brf_pkg::*;
(
  input  logic [4:0] mode_i,
  output bank_e      bank_o
);
  always_comb begin
    unique case (mode_i)
      MD_FIQ:  bank_o = BK_FIQ;
      MD_IRQ:  bank_o = BK_IRQ;
      MD_SVC:  bank_o = BK_SVC;
      MD_ABT:  bank_o = BK_ABT;
      MD_UND:  bank_o = BK_UND;
      default: bank_o = BK_USR;
    endcase
  end
endmodule

// File: rtl/brf_index_map.sv
module brf_index_map
  import brf_pkg::*;
(
  input  bank_e              bank_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [PHYS_W-1:0]  phys_o
);
  int slot;

  always_comb begin
    slot = int'(idx_i);
    if (bank_i == BK_FIQ && slot >= FIQ_LO && slot <= FIQ_HI) begin
      slot = ARCH_N + (slot - FIQ_LO);
    end else if (bank_i != BK_USR && (slot == SP_IDX || slot == LR_IDX)) begin
      slot = ARCH_N + FIQ_CNT + 2 * (int'(bank_i) - 1) + (slot - SP_IDX);
    end
    phys_o = PHYS_W'(slot);
  end

  always_comb begin
    AST_PHYS_IN_RANGE: assert (int'(phys_o) < PHYS_N); // R4
    if (int'(idx_i) < FIQ_LO || int'(idx_i) == ARCH_N - 1)
      AST_LOW_SHARED: assert (phys_o == PHYS_W'(idx_i)); // R2
  end
endmodule

// File: rtl/brf_storage.sv
module brf_storage
  import brf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [PHYS_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PHYS_W-1:0] raddr_a,
  input  logic [PHYS_W-1:0] raddr_b,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [PHYS_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < PHYS_N; i++) mem[i] <= '0;
    end else if (we && int'(waddr) < PHYS_N) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata_a = (int'(raddr_a) < PHYS_N) ? mem[raddr_a] : '0;
  assign rdata_b = (int'(raddr_b) < PHYS_N) ? mem[raddr_b] : '0;

  AST_USER_SP_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && int'(waddr) == SP_IDX) |=> $stable(mem[SP_IDX])); // R4
endmodule

// File: rtl/brf_saved_status.sv
module brf_saved_status
  import brf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_e             bank_i,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] word [SAV_N];
  logic              has_word;
  int                sel;

  always_comb begin
    has_word = (bank_i != BK_USR);
    sel      = has_word ? int'(bank_i) - 1 : 0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SAV_N; i++) word[i] <= '0;
    end else if (we && has_word) begin
      word[sel] <= wdata;
    end
  end

  assign rdata = has_word ? word[sel] : '0;
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import brf_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4:0]        mode_i,
  input  logic [3:0]        rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [3:0]        rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [3:0]        wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] sav_rd_data,
  input  logic              sav_wr_en,
  input  logic [DATA_W-1:0] sav_wr_data
);
  localparam int PORT_N = 3;

  bank_e             bank;
  logic [IDX_W-1:0]  map_idx  [PORT_N];
  logic [PHYS_W-1:0] map_phys [PORT_N];

  brf_mode_decode u_decode (
    .mode_i (mode_i),
    .bank_o (bank)
  );

  assign map_idx[0] = rd_a_idx;
  assign map_idx[1] = rd_b_idx;
  assign map_idx[2] = wr_idx;

  for (genvar p = 0; p < PORT_N; p++) begin : g_map
    brf_index_map u_map (
      .bank_i (bank),
      .idx_i  (map_idx[p]),
      .phys_o (map_phys[p])
    );
  end

  brf_storage #(.DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_en),
    .waddr   (map_phys[2]),
    .wdata   (wr_data),
    .raddr_a (map_phys[0]),
    .raddr_b (map_phys[1]),
    .rdata_a (rd_a_data),
    .rdata_b (rd_b_data)
  );

  brf_saved_status #(.DATA_W(DATA_W)) u_sav (
    .clk   (clk),
    .rst_n (rst_n),
    .bank_i(bank),
    .we    (sav_wr_en),
    .wdata (sav_wr_data),
    .rdata (sav_rd_data)
  );

  AST_SAV_UNBANKED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MD_USR || mode_i == MD_SYS) |-> (sav_rd_data == '0)); // R8

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (!($stable(mode_i) && $stable(rd_a_idx)) || $stable(rd_a_data))); // R9

  AST_SAV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sav_wr_en |=> (!$stable(mode_i) || $stable(sav_rd_data))); // R7
endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode_i = 5'h10;
  logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = '0, sav_rd_data, sav_wr_data = '0;
  logic        wr_en = 1'b0, sav_wr_en = 1'b0;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  banked_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .sav_rd_data(sav_rd_data), .sav_wr_en(sav_wr_en), .sav_wr_data(sav_wr_data)
  );

  localparam logic [4:0] U = 5'h10, F = 5'h11, I = 5'h12, S = 5'h13,
                         A = 5'h17, D = 5'h1B, Y = 5'h1F, X = 5'h00;
  localparam int NV = 18;
  // {mode, we, widx, wdata, aidx, aexp, bidx, bexp}; reads checked before the row's write commits
  localparam logic [113:0] VEC [NV] = '{
    {U, 1'b1, 4'd13, 32'h1111_0013, 4'd13, 32'h0,         4'd0,  32'h0},
    {U, 1'b1, 4'd8,  32'h0000_0008, 4'd13, 32'h1111_0013, 4'd8,  32'h0},
    {F, 1'b1, 4'd8,  32'hF000_0008, 4'd8,  32'h0,         4'd13, 32'h0},
    {F, 1'b1, 4'd13, 32'hF000_0013, 4'd8,  32'hF000_0008, 4'd0,  32'h0},
    {I, 1'b1, 4'd13, 32'h1200_0013, 4'd13, 32'h0,         4'd8,  32'h0000_0008},
    {S, 1'b1, 4'd14, 32'h1300_0014, 4'd13, 32'h0,         4'd14, 32'h0},
    {A, 1'b1, 4'd13, 32'h1700_0013, 4'd14, 32'h0,         4'd13, 32'h0},
    {D, 1'b1, 4'd13, 32'h1B00_0013, 4'd13, 32'h0,         4'd8,  32'h0000_0008},
    {Y, 1'b1, 4'd14, 32'h1F00_0014, 4'd13, 32'h1111_0013, 4'd8,  32'h0000_0008},
    {U, 1'b1, 4'd0,  32'hAAAA_0000, 4'd14, 32'h1F00_0014, 4'd13, 32'h1111_0013},
    {F, 1'b0, 4'd0,  32'h0,         4'd13, 32'hF000_0013, 4'd0,  32'hAAAA_0000},
    {I, 1'b0, 4'd0,  32'h0,         4'd13, 32'h1200_0013, 4'd14, 32'h0},
    {S, 1'b0, 4'd0,  32'h0,         4'd14, 32'h1300_0014, 4'd15, 32'h0},
    {A, 1'b0, 4'd0,  32'h0,         4'd13, 32'h1700_0013, 4'd14, 32'h0},
    {D, 1'b0, 4'd0,  32'h0,         4'd13, 32'h1B00_0013, 4'd12, 32'h0},
    {X, 1'b0, 4'd0,  32'h0,         4'd13, 32'h1111_0013, 4'd14, 32'h1F00_0014},
    {F, 1'b1, 4'd15, 32'h0000_0F15, 4'd15, 32'h0,         4'd9,  32'h0},
    {U, 1'b0, 4'd0,  32'h0,         4'd15, 32'h0000_0F15, 4'd8,  32'h0000_0008}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sav_put(input logic [4:0] m, input logic [31:0] v);
    @(negedge clk);
    mode_i = m; sav_wr_en = 1'b1; sav_wr_data = v;
    @(negedge clk);
    sav_wr_en = 1'b0;
  endtask

  task automatic sav_get(input string tag, input logic [4:0] m, input logic [31:0] exp);
    @(negedge clk);
    mode_i = m; sav_wr_en = 1'b0;
    #1 chk(tag, sav_rd_data, exp);
  endtask

  initial begin
    #4_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: every index reads zero after reset
    @(negedge clk);
    for (int k = 0; k < 16; k++) begin
      rd_a_idx = 4'(k); rd_b_idx = 4'(15 - k);
      #1 chk("R1 reset port A", rd_a_data, 32'h0);
      chk("R1 reset port B", rd_b_data, 32'h0);
    end
    sav_get("R1 reset saved status", S, 32'h0);

    // Vector walk: R2 R3 R4 R5 R6 R9 R10
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      mode_i   = VEC[v][113:109];
      wr_en    = VEC[v][108];
      wr_idx   = VEC[v][107:104];
      wr_data  = VEC[v][103:72];
      rd_a_idx = VEC[v][71:68];
      rd_b_idx = VEC[v][35:32];
      #1;
      chk($sformatf("R2 R3 R4 R5 R6 R9 R10 row %0d port A", v), rd_a_data, VEC[v][67:36]);
      chk($sformatf("R2 R3 R4 R5 R6 R9 R10 row %0d port B", v), rd_b_data, VEC[v][31:0]);
    end
    @(negedge clk);
    wr_en = 1'b0;

    // R9: written value visible after the edge
    mode_i = U; rd_a_idx = 4'd0; #1;
    chk("R9 write visible after edge", rd_a_data, 32'hAAAA_0000);

    // R7: five private saved-status words
    sav_put(F, 32'h5A00_0011);
    sav_put(I, 32'h5A00_0012);
    sav_put(S, 32'h5A00_0013);
    sav_put(A, 32'h5A00_0017);
    sav_put(D, 32'h5A00_001B);
    sav_get("R7 saved fiq", F, 32'h5A00_0011);
    sav_get("R7 saved irq", I, 32'h5A00_0012);
    sav_get("R7 saved svc", S, 32'h5A00_0013);
    sav_get("R7 saved abt", A, 32'h5A00_0017);
    sav_get("R7 saved und", D, 32'h5A00_001B);

    // R8: unbanked modes read zero and writes are dropped
    sav_put(U, 32'hDEAD_0001);
    sav_put(Y, 32'hDEAD_0002);
    sav_put(X, 32'hDEAD_0003);
    sav_get("R8 user reads zero", U, 32'h0);
    sav_get("R8 system reads zero", Y, 32'h0);
    sav_get("R8 unknown mode reads zero", X, 32'h0);
    sav_get("R8 fiq untouched", F, 32'h5A00_0011);
    sav_get("R8 irq untouched", I, 32'h5A00_0012);
    sav_get("R8 svc untouched", S, 32'h5A00_0013);
    sav_get("R8 abt untouched", A, 32'h5A00_0017);
    sav_get("R8 und untouched", D, 32'h5A00_001B);

    // R6: another unrecognised code writes the user r13
    @(negedge clk);
    mode_i = 5'h15; wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'h6600_0013;
    @(negedge clk);
    wr_en = 1'b0; mode_i = U; rd_a_idx = 4'd13; rd_b_idx = 4'd13;
    #1 chk("R6 unknown code hits user r13", rd_a_data, 32'h6600_0013);
    mode_i = S; #1 chk("R6 svc r13 separate", rd_b_data, 32'h0);

    // R1: reset again clears banked and saved contents
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    mode_i = F; rd_a_idx = 4'd13; rd_b_idx = 4'd8;
    #1 chk("R1 re-reset fiq r13", rd_a_data, 32'h0);
    chk("R1 re-reset fiq r8", rd_b_data, 32'h0);
    chk("R1 re-reset fiq saved", sav_rd_data, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule